// File: doc/BRIEF.md
# Aligned Programmable Clock Divider Bank

This block derives several divided clocks from one fast source clock. Each channel has an enable and a 5-bit ratio. A ratio value n gives a clock with a period of n+1 source cycles and a 50% duty cycle. The `clk` input runs at the source edge rate: one `clk` cycle is one half-period of the source. This lets odd ratios have equal high and low times using only rising-edge logic.

Ratio values sit on a staged input and have no effect on their own. A one-cycle GO request latches an alignment mask and raises `busy_o`. Each selected channel then finishes its current period and parks with its output low. Once every selected channel is parked, all of them load their staged ratios and restart with a rising edge in the same cycle, and `busy_o` drops in that same cycle. Channels outside the mask keep running at their old ratio throughout.

The block has no registers of its own that software can reach. Enables, staged ratios, the alignment mask and the GO pulse come from a register block outside it.

Top module: `clk_align_bank`

## Requirements
- R1: An enabled channel whose active ratio is n drives its output high for exactly n+1 `clk` cycles and then low for exactly n+1 `clk` cycles, for every n from 0 to 31.
- R2: While `div_en_i[i]` is 0, output `div_clk_o[i]` is 0 from the next cycle on. After it returns to 1, the output stays low for exactly n more cycles (n = active ratio) and then rises.
- R3: The staged ratio of channel i, on `ratio_stage_i[5i+4:5i]`, does not change that channel's divide ratio until a GO that selects channel i completes.
- R4: During a GO, every selected channel finishes its current period and holds its output low. All selected enabled channels then rise in the same cycle and run at their staged ratios.
- R5: A channel whose bit in `align_i` is 0 at the time of the GO keeps toggling at its old ratio through the GO and afterwards.
- R6: `busy_o` is 1 from the cycle after an accepted GO until the release edge. It falls on the same edge at which the selected outputs rise.
- R7: After reset the active ratios are 0, 1 and 2 (divide by 1, 2, 3) for channels 0, 1 and 2, all outputs are low and `busy_o` is 0.
- R8: A `go_i` pulse that arrives while `busy_o` is 1 is ignored. Neither its `align_i` value nor its staged ratios are applied.
- R9: A GO with `align_i` equal to 0 holds `busy_o` high for exactly one cycle and changes no ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, one cycle per source half-period |
| rst | input | 1 | Synchronous active-high reset |
| div_en_i | input | NUM_DIV | Enable per channel; bit i belongs to channel i |
| ratio_stage_i | input | NUM_DIV*RATIO_W | Staged ratios; channel i at bits [RATIO_W*i +: RATIO_W] |
| align_i | input | NUM_DIV | Alignment mask sampled with an accepted GO; bit i selects channel i |
| go_i | input | 1 | Single-cycle GO request |
| busy_o | output | 1 | GO in progress |
| div_clk_o | output | NUM_DIV | Divided clock outputs; bit i is channel i |

## Verification
The bench builds the block with its defaults: three channels and 5-bit ratios. With these values it can reach the full ratio span, including the 32-cycle half-period of ratio 31. It can also set up mixed alignment masks in which one channel parks for a long period while another parks almost at once, and it can exercise the reset ratios 0, 1 and 2 directly. The bench measures high and low run lengths at the ports. For each GO it also compares the cycle in which `busy_o` falls with the cycle in which the selected outputs rise.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    // Per-channel command from the GO sequencer
    typedef struct packed {
        logic hold_req;   // finish current period, then park low
        logic release_s;  // load staged ratio and restart high
    } ch_ctl_t;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_PARK = 1'b1
    } ch_phase_t;

    // Ratio a channel takes out of reset: channel k divides by k+1
    function automatic int reset_ratio(int idx);
        return idx;
    endfunction

endpackage

// File: rtl/div_chan.sv
module div_chan
    import clkbank_pkg::*;
#(
    parameter int RATIO_W = 5,
    parameter logic [RATIO_W-1:0] RESET_RATIO = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] stage_i,
    input  ch_ctl_t            ctl_i,
    output logic               clk_o,
    output logic               parked_o
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;
    logic               out_q;
    ch_phase_t          ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= RESET_RATIO;
            out_q <= 1'b0;
            ph_q  <= PH_RUN;
        end else if (ctl_i.release_s) begin
            act_q <= stage_i;
            cnt_q <= '0;
            ph_q  <= PH_RUN;
            out_q <= en_i;
        end else if (!en_i) begin
            cnt_q <= '0;
            out_q <= 1'b0;
            ph_q  <= ctl_i.hold_req ? PH_PARK : PH_RUN;
        end else if (ph_q == PH_PARK) begin
            cnt_q <= '0;
        end else if (cnt_q == act_q) begin
            cnt_q <= '0;
            if (!out_q && ctl_i.hold_req) begin
                ph_q <= PH_PARK;
            end else begin
                out_q <= ~out_q;
            end
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end

    assign clk_o    = out_q;
    assign parked_o = (ph_q == PH_PARK);

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !clk_o); // R2
    AST_PARK_LOW: assert property (@(posedge clk) disable iff (rst)
        parked_o |-> !clk_o); // R4
    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.release_s |=> $stable(act_q)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= act_q); // R1

endmodule

// File: rtl/go_seq.sv
module go_seq
    import clkbank_pkg::*;
#(
    parameter int NUM_DIV = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       go_i,
    input  logic [NUM_DIV-1:0]         align_i,
    input  logic [NUM_DIV-1:0]         parked_i,
    output logic                       busy_o,
    output ch_ctl_t [NUM_DIV-1:0]      ctl_o
);

    logic               busy_q;
    logic [NUM_DIV-1:0] mask_q;
    logic               all_parked;
    logic               release_w;

    assign all_parked = &(parked_i | ~mask_q);
    assign release_w  = busy_q && all_parked;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            mask_q <= '0;
        end else if (busy_q) begin
            if (all_parked) busy_q <= 1'b0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            mask_q <= align_i;
        end
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_ctl
        assign ctl_o[g].hold_req  = busy_q & mask_q[g];
        assign ctl_o[g].release_s = release_w & mask_q[g];
    end

    assign busy_o = busy_q;

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        (busy_q && all_parked) |=> !busy_q); // R6
    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(mask_q)); // R8
    AST_EMPTY_GO: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && go_i && align_i == '0) |=> busy_q ##1 !busy_q); // R9

endmodule

// File: rtl/clk_align_bank.sv
module clk_align_bank
    import clkbank_pkg::*;
#(
    parameter int NUM_DIV = 3,
    parameter int RATIO_W = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_DIV-1:0]         div_en_i,
    input  logic [NUM_DIV*RATIO_W-1:0] ratio_stage_i,
    input  logic [NUM_DIV-1:0]         align_i,
    input  logic                       go_i,
    output logic                       busy_o,
    output logic [NUM_DIV-1:0]         div_clk_o
);

    ch_ctl_t [NUM_DIV-1:0] ctl_w;
    logic    [NUM_DIV-1:0] parked_w;

    go_seq #(.NUM_DIV(NUM_DIV)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_i     (go_i),
        .align_i  (align_i),
        .parked_i (parked_w),
        .busy_o   (busy_o),
        .ctl_o    (ctl_w)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_chan
        div_chan #(
            .RATIO_W     (RATIO_W),
            .RESET_RATIO (RATIO_W'(reset_ratio(g)))
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en_i     (div_en_i[g]),
            .stage_i  (ratio_stage_i[g*RATIO_W +: RATIO_W]),
            .ctl_i    (ctl_w[g]),
            .clk_o    (div_clk_o[g]),
            .parked_o (parked_w[g])
        );
    end

endmodule

// File: tb/tb_clk_align_bank.sv
`timescale 1ns/1ps
module tb_clk_align_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  div_en;
    logic [14:0] stage;
    logic [2:0]  align;
    logic        go;
    logic        busy;
    logic [2:0]  div_clk;

    int nchk = 0;
    int nfail = 0;
    int exp_r [3];

    always #2 clk = ~clk;

    clk_align_bank dut (
        .clk(clk), .rst(rst), .div_en_i(div_en), .ratio_stage_i(stage),
        .align_i(align), .go_i(go), .busy_o(busy), .div_clk_o(div_clk)
    );

    // {mask, r2, r1, r0}
    localparam logic [17:0] VEC [6] = '{
        {3'b111, 5'd7,  5'd5, 5'd3},
        {3'b011, 5'd2,  5'd1, 5'd0},
        {3'b100, 5'd4,  5'd4, 5'd4},
        {3'b111, 5'd9,  5'd0, 5'd31},
        {3'b000, 5'd2,  5'd2, 5'd2},
        {3'b101, 5'd0,  5'd2, 5'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        while (div_clk[ch]) @(negedge clk);
        while (!div_clk[ch]) @(negedge clk);
        hi = 0;
        while (div_clk[ch]) begin hi++; @(negedge clk); end
        lo = 0;
        while (!div_clk[ch]) begin lo++; @(negedge clk); end
    endtask

    task automatic check_all(input string req);
        int hi, lo;
        for (int c = 0; c < 3; c++) begin
            measure(c, hi, lo);
            chk(hi == exp_r[c] + 1, req, hi, exp_r[c] + 1);
            chk(lo == exp_r[c] + 1, req, lo, exp_r[c] + 1);
        end
    endtask

    // Issue GO and check busy window and aligned rise (R4, R6, R9)
    task automatic run_go(input logic [2:0] m);
        logic [2:0] prev;
        int nb;
        align = m;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R6 busy after GO", busy, 1);
        nb = 0;
        prev = div_clk;
        while (busy) begin
            prev = div_clk;
            nb++;
            @(negedge clk);
        end
        if (m == 3'b000) begin
            chk(nb == 1, "R9 empty GO busy length", nb, 1);
        end else begin
            chk((prev & m) == 3'b000, "R4 parked low before release", prev & m, 0);
            chk((div_clk & m) == m, "R4 R6 aligned rise with busy fall", div_clk & m, m);
        end
        for (int c = 0; c < 3; c++)
            if (m[c]) exp_r[c] = int'(stage[c*5 +: 5]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; div_en = 3'b111; stage = {5'd2, 5'd1, 5'd0};
        align = 3'b000; go = 1'b0;
        exp_r[0] = 0; exp_r[1] = 1; exp_r[2] = 2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(div_clk == 3'b000, "R7 outputs low after reset", div_clk, 0);
        chk(busy == 1'b0, "R7 busy low after reset", busy, 0);
        check_all("R7 R1 reset ratios");

        // R3: staged values alone change nothing
        stage = {5'd7, 5'd5, 5'd3};
        repeat (40) @(negedge clk);
        check_all("R3 staged ratio not applied");

        // Table walk: R1, R4, R5, R9
        for (int v = 0; v < 6; v++) begin
            stage = VEC[v][14:0];
            run_go(VEC[v][17:15]);
            check_all("R1 R5 ratios after GO");
        end

        // R8: second GO while busy is ignored
        stage = {5'd6, 5'd6, 5'd3};
        align = 3'b001;
        go = 1'b1;
        @(negedge clk);
        align = 3'b110;
        chk(busy == 1'b1, "R8 busy during first GO", busy, 1);
        @(negedge clk);
        go = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        exp_r[0] = 3;
        check_all("R8 GO while busy ignored");

        // R2: disable then re-enable channel 1
        @(negedge clk);
        div_en[1] = 1'b0;
        @(negedge clk);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (div_clk[1]) n++;
            @(negedge clk);
        end
        chk(n == 0, "R2 disabled output stays low", n, 0);
        div_en[1] = 1'b1;
        @(negedge clk);
        n = 0;
        while (!div_clk[1] && n < 40) begin n++; @(negedge clk); end
        chk(n == exp_r[1], "R2 re-enable low run", n, exp_r[1]);
        check_all("R2 R1 after re-enable");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule